// File: doc/BRIEF.md
# Window/Timeout Watchdog Supervisor

This block supervises a microcontroller through register writes arriving on a small host write port, which stands in for a serial register interface. A millisecond tick drives a period counter. In window mode each period has two halves. The first half is closed: a clear there counts as a failure. The second half is open, and a clear there restarts the period. In timeout mode a clear is accepted at any point in the period. If no clear arrives, the period runs out and a fault is raised.

A fault always pulls a latched watchdog-fault output low. That output rises again only after a valid clear. The reset-mode input decides whether the fault also produces a reset pulse of fixed length. In the default mode it does. In safe mode the reset line stays high. The reset output also follows a supply-good input, so it is held low while the supply is out of range. The counter runs only while the system-mode input reports Normal or Standby.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst_n` is low, both `rst_n_o` and `wdf_n_o` are low. After reset is released (two-flop synchronizer), with supply good, both outputs are high. After reset the configuration is window mode with period select 0.
- R2: With no clear, the P-th tick after a restart raises a fault. P is the period of the active configuration, and P = 10 ticks for select 0. After P-1 ticks there is no fault yet.
- R3: In window mode, a clear (a write to address 0) when fewer than P/2 ticks have passed since the restart is a fault.
- R4: In window mode, a clear when at least P/2 ticks have passed is valid. It restarts the count, so no fault occurs until P further ticks.
- R5: In timeout mode (configuration bit 2 = 1), a clear is valid at any count, including 1 tick after a restart.
- R6: Configuration bits [1:0] select the period: 0→10, 1→45, 2→100, 3→350 ticks.
- R7: A write to address 1 stores a pending configuration. It becomes active only at the next restart, which is a valid clear, a fault, or any idle cycle.
- R8: In reset mode 1 (`rst_mode_i` = 0), a fault drives `rst_n_o` low for 3 ticks (RST_DUR). Afterwards `rst_n_o` returns high, `wdf_n_o` stays low, and the counter restarts.
- R9: In safe mode (`rst_mode_i` = 1), a fault drives `wdf_n_o` low and leaves `rst_n_o` high.
- R10: While `supply_ok_i` = 0, `rst_n_o` is low in the same cycle and `wdf_n_o` stays high. The counter is held at zero until the supply is good again.
- R11: When `sys_mode_i` is Stop (2) or Sleep (3), the counter is held at zero. Ticks and clears then raise no fault. Normal is 0 and Standby is 1.
- R12: Once low, `wdf_n_o` returns high only on a valid clear. An early clear, or a write to an unused address (2 or 3), leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle pulse per millisecond tick |
| sys_mode_i | input | 2 | System mode: 0 Normal, 1 Standby, 2 Stop, 3 Sleep |
| rst_mode_i | input | 1 | 0: a fault pulses reset; 1: safe mode, fault output only |
| supply_ok_i | input | 1 | Supply within range |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Write address: 0 clear, 1 configuration |
| wr_data_i | input | 3 | Configuration data: [2] timeout mode, [1:0] period select |
| rst_n_o | output | 1 | Active-low reset to the microcontroller |
| wdf_n_o | output | 1 | Active-low latched watchdog fault |

## Verification
The hardest situation to reach is a clear that lands exactly on the boundary between the closed and open halves, on a period that has just been switched by a pending configuration. The bench counts the ticks it sends after each restart, so it knows the count inside the block without looking at it. It writes at P/2-1 and at P/2 in separate scenarios. It also changes the configuration first and then forces a restart, so the new period and the new mode are checked only after the restart that brings them in.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 2'd1;

  typedef enum logic [1:0] {
    SM_NORMAL  = 2'd0,
    SM_STANDBY = 2'd1,
    SM_STOP    = 2'd2,
    SM_SLEEP   = 2'd3
  } sys_mode_e;

  typedef struct packed {
    logic       timeout;
    logic [1:0] per_sel;
  } wdg_cfg_t;

  localparam wdg_cfg_t CFG_RESET = '{timeout: 1'b0, per_sel: 2'd0};
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer
  import wdg_pkg::*;
#(
  parameter int unsigned P0 = 10,
  parameter int unsigned P1 = 45,
  parameter int unsigned P2 = 100,
  parameter int unsigned P3 = 350
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     active_i,
  input  logic     clr_hit_i,
  input  logic     cfg_hit_i,
  input  wdg_cfg_t cfg_data_i,
  output logic     clear_ok_o,
  output logic     fault_evt_o
);
  localparam int unsigned MAX01 = (P0 > P1) ? P0 : P1;
  localparam int unsigned MAX23 = (P2 > P3) ? P2 : P3;
  localparam int unsigned MAXP  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned PER_W = $clog2(MAXP + 1);

  function automatic logic [PER_W-1:0] period_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return PER_W'(P0);
      2'd1:    return PER_W'(P1);
      2'd2:    return PER_W'(P2);
      default: return PER_W'(P3);
    endcase
  endfunction

  logic [PER_W-1:0] cnt_q, cnt_d;
  wdg_cfg_t         pend_q, pend_d, act_q, act_d;
  logic [PER_W-1:0] per, half;
  logic             in_closed, early, expire, restart;

  assign per       = period_of(act_q.per_sel);
  assign half      = per >> 1;
  assign in_closed = !act_q.timeout && (cnt_q < half);
  assign early     = active_i && clr_hit_i && in_closed;
  assign clear_ok_o  = active_i && clr_hit_i && !in_closed;
  assign expire    = active_i && tick_i && (cnt_q == per - 1'b1);
  assign fault_evt_o = early || (expire && !clear_ok_o);
  assign restart   = !active_i || clear_ok_o || fault_evt_o;

  always_comb begin
    pend_d = cfg_hit_i ? cfg_data_i : pend_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (restart) begin
      cnt_d = '0;
      act_d = pend_d;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= CFG_RESET;
      act_q  <= CFG_RESET;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period_of(act_q.per_sel));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0));
  p_timeout_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && clr_hit_i && act_q.timeout) |-> !fault_evt_o);
endmodule

// File: rtl/wdg_fault_ctrl.sv
module wdg_fault_ctrl #(
  parameter int unsigned RST_DUR = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic safe_i,
  input  logic fault_evt_i,
  input  logic clear_ok_i,
  output logic fault_lat_o,
  output logic pulse_busy_o
);
  localparam int unsigned PW = $clog2(RST_DUR + 1);

  logic          lat_q, lat_d, busy_q, busy_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    lat_d  = lat_q;
    busy_d = busy_q;
    pcnt_d = pcnt_q;
    if (fault_evt_i)     lat_d = 1'b1;
    else if (clear_ok_i) lat_d = 1'b0;
    if (busy_q) begin
      if (tick_i) begin
        if (pcnt_q == PW'(RST_DUR - 1)) begin
          busy_d = 1'b0;
          pcnt_d = '0;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
    end else if (fault_evt_i && !safe_i) begin
      busy_d = 1'b1;
      pcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= 1'b0;
      busy_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      lat_q  <= lat_d;
      busy_q <= busy_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign fault_lat_o  = lat_q;
  assign pulse_busy_o = busy_q;

  p_latch_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt_i |=> lat_q);
  p_safe_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && safe_i) |=> !busy_q);
  p_pulse_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pcnt_q < PW'(RST_DUR)));
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int unsigned P0      = 10,
  parameter int unsigned P1      = 45,
  parameter int unsigned P2      = 100,
  parameter int unsigned P3      = 350,
  parameter int unsigned RST_DUR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        sys_mode_i,
  input  logic              rst_mode_i,
  input  logic              supply_ok_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rst_n_o,
  output logic              wdf_n_o
);
  logic     rst_sync_n, mode_run, active, clr_hit, cfg_hit;
  logic     clear_ok, fault_evt, fault_lat, pulse_busy;
  wdg_cfg_t cfg_data;

  wdg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign mode_run = (sys_mode_i == SM_NORMAL) || (sys_mode_i == SM_STANDBY);
  assign active   = mode_run && supply_ok_i && !pulse_busy;
  assign clr_hit  = wr_en_i && (wr_addr_i == ADDR_CLEAR);
  assign cfg_hit  = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign cfg_data = wdg_cfg_t'(wr_data_i);

  wdg_window_timer #(.P0(P0), .P1(P1), .P2(P2), .P3(P3)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i), .active_i(active),
    .clr_hit_i(clr_hit), .cfg_hit_i(cfg_hit), .cfg_data_i(cfg_data),
    .clear_ok_o(clear_ok), .fault_evt_o(fault_evt)
  );

  wdg_fault_ctrl #(.RST_DUR(RST_DUR)) u_fault (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i), .safe_i(rst_mode_i),
    .fault_evt_i(fault_evt), .clear_ok_i(clear_ok),
    .fault_lat_o(fault_lat), .pulse_busy_o(pulse_busy)
  );

  assign rst_n_o = rst_sync_n && supply_ok_i && !pulse_busy;
  assign wdf_n_o = rst_sync_n && !fault_lat;

  p_supply_rst_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_ok_i |-> !rst_n_o);
  p_wdf_release_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(wdf_n_o) && $past(rst_sync_n)) |-> $past(clear_ok));
  p_safe_rst_high_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_mode_i && $past(rst_mode_i) && supply_ok_i && !pulse_busy) |=>
      (!supply_ok_i || rst_n_o));
endmodule

// File: tb/wdg_supervisor_tb_top.sv
module wdg_supervisor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, rst_mode_i, supply_ok_i, wr_en_i;
  logic [1:0] sys_mode_i, wr_addr_i;
  logic [2:0] wr_data_i;
  logic       rst_n_o, wdf_n_o;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  wdg_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sys_mode_i(sys_mode_i),
    .rst_mode_i(rst_mode_i), .supply_ok_i(supply_ok_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rst_n_o(rst_n_o), .wdf_n_o(wdf_n_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit safe);
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = 2'd0; wr_data_i = 3'd0;
    sys_mode_i = 2'd0; rst_mode_i = safe; supply_ok_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk) begin wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; end
    @(negedge clk) wr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; supply_ok_i = 1'b1; tick_i = 1'b0; wr_en_i = 1'b0;
    sys_mode_i = 2'd0; rst_mode_i = 1'b0; wr_addr_i = 2'd0; wr_data_i = 3'd0;
    repeat (2) @(negedge clk);
    chk(rst_n_o == 1'b0, "R1 rst_n_o in reset", rst_n_o, 0);
    chk(wdf_n_o == 1'b0, "R1 wdf_n_o in reset", wdf_n_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rst_n_o == 1'b1, "R1 rst_n_o after release", rst_n_o, 1);
    chk(wdf_n_o == 1'b1, "R1 wdf_n_o after release", wdf_n_o, 1);
  endtask

  task automatic t_expiry;
    do_reset(1'b0);
    ticks(9);
    chk(wdf_n_o == 1'b1, "R2 no fault at P-1", wdf_n_o, 1);
    ticks(1);
    chk(wdf_n_o == 1'b0, "R2 fault at P", wdf_n_o, 0);
  endtask

  task automatic t_early_clear;
    do_reset(1'b1);
    ticks(4);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b0, "R3 clear at P/2-1 faults", wdf_n_o, 0);
  endtask

  task automatic t_open_clear;
    do_reset(1'b1);
    ticks(5);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b1, "R4 clear at P/2 valid", wdf_n_o, 1);
    ticks(9);
    chk(wdf_n_o == 1'b1, "R4 restarted, no fault at P-1", wdf_n_o, 1);
    ticks(1);
    chk(wdf_n_o == 1'b0, "R4 fault P ticks after clear", wdf_n_o, 0);
  endtask

  task automatic t_timeout_mode;
    do_reset(1'b1);
    wr(2'd1, 3'b100);
    ticks(4);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b0, "R7 pending cfg not yet active", wdf_n_o, 0);
    ticks(1);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b1, "R5 timeout-mode clear after 1 tick", wdf_n_o, 1);
  endtask

  task automatic t_period(input logic [1:0] sel, input int p);
    do_reset(1'b1);
    wr(2'd1, {1'b0, sel});
    ticks(5);
    wr(2'd0, 3'd0);
    ticks(p - 1);
    chk(wdf_n_o == 1'b1, "R6 no fault at P-1", wdf_n_o, 1);
    ticks(1);
    chk(wdf_n_o == 1'b0, "R6 fault at P", wdf_n_o, 0);
  endtask

  task automatic t_reset_pulse;
    do_reset(1'b0);
    ticks(10);
    chk(rst_n_o == 1'b0, "R8 reset pulse starts", rst_n_o, 0);
    ticks(2);
    chk(rst_n_o == 1'b0, "R8 reset held 2 ticks", rst_n_o, 0);
    ticks(1);
    chk(rst_n_o == 1'b1, "R8 reset ends after 3 ticks", rst_n_o, 1);
    chk(wdf_n_o == 1'b0, "R8 wdf stays low after pulse", wdf_n_o, 0);
    ticks(5);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b1, "R12 valid clear releases wdf", wdf_n_o, 1);
  endtask

  task automatic t_safe;
    do_reset(1'b1);
    ticks(10);
    chk(wdf_n_o == 1'b0, "R9 wdf low on fault", wdf_n_o, 0);
    chk(rst_n_o == 1'b1, "R9 reset stays high", rst_n_o, 1);
  endtask

  task automatic t_supply;
    do_reset(1'b0);
    ticks(3);
    @(negedge clk) supply_ok_i = 1'b0;
    #1;
    chk(rst_n_o == 1'b0, "R10 reset follows supply", rst_n_o, 0);
    chk(wdf_n_o == 1'b1, "R10 wdf high on supply loss", wdf_n_o, 1);
    ticks(20);
    chk(wdf_n_o == 1'b1, "R10 no fault while supply bad", wdf_n_o, 1);
    @(negedge clk) supply_ok_i = 1'b1;
    #1;
    chk(rst_n_o == 1'b1, "R10 reset released", rst_n_o, 1);
    ticks(9);
    chk(wdf_n_o == 1'b1, "R10 counter restarted", wdf_n_o, 1);
  endtask

  task automatic t_inactive;
    do_reset(1'b0);
    @(negedge clk) sys_mode_i = 2'd2;
    ticks(30);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b1, "R11 stop: no fault", wdf_n_o, 1);
    @(negedge clk) sys_mode_i = 2'd3;
    ticks(12);
    chk(rst_n_o == 1'b1, "R11 sleep: no reset", rst_n_o, 1);
    @(negedge clk) sys_mode_i = 2'd1;
    ticks(9);
    chk(wdf_n_o == 1'b1, "R11 standby restarts at zero", wdf_n_o, 1);
    ticks(1);
    chk(wdf_n_o == 1'b0, "R11 standby expiry faults", wdf_n_o, 0);
  endtask

  task automatic t_latch_hold;
    do_reset(1'b1);
    ticks(10);
    ticks(4);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b0, "R12 early clear keeps wdf low", wdf_n_o, 0);
    ticks(6);
    wr(2'd2, 3'd0);
    wr(2'd3, 3'd0);
    chk(wdf_n_o == 1'b0, "R12 unused address ignored", wdf_n_o, 0);
    wr(2'd0, 3'd0);
    chk(wdf_n_o == 1'b1, "R12 valid clear releases", wdf_n_o, 1);
  endtask

  initial begin
    t_reset();
    t_expiry();
    t_early_clear();
    t_open_clear();
    t_timeout_mode();
    t_period(2'd1, 45);
    t_period(2'd3, 350);
    t_reset_pulse();
    t_safe();
    t_supply();
    t_inactive();
    t_latch_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule